// File: doc/BRIEF.md
# CPU Clock Rate-Change Sequencer

This block carries out the register writes a CPU clock domain needs when its main PLL changes frequency. When a request arrives, it moves the core clock mux onto an alternate source. If the alternate source is faster than the old rate, the block applies a parking divider in the same write, so the core never runs faster than it did before the change. It then waits for the PLL to report lock.

After lock, it looks up the new rate in a small table of auxiliary divider settings. It writes those settings and returns the core to the main source with the divider cleared. The order of these two steps depends on the direction of the change.

All writes use a masked format: the upper 16 bits of a write enable the matching lower 16 data bits. The block keeps a shadow of the core control register. From that shadow it reports the selected source, the divider and the resulting core rate. A separate load port fills the table.

Top module: `cpu_rate_sequencer`

## Requirements
- R1: A request is accepted only while `busy` is low. `busy` stays high from the cycle after acceptance until the cycle after the one-cycle `done` pulse. `wr_valid` is only ever high while `busy` is high.
- R2: When the alternate rate is greater than the old rate, the first write goes to the core register address 0x50 with enable 0x1F40 and data `(d<<8)|0x40`. Here d = ceil(alt/old) - 1, bits [12:8] are the core divider and bit 6 is the mux select (1 = alternate). The mux and the divider therefore change in the same write.
- R3: A parking divider above 31, the largest value of the divider field, is written as 31.
- R4: When the alternate rate is not greater than the old rate, the first write is 0x0040_0040 to address 0x50. It changes only the mux bit and leaves the divider as it was.
- R5: After the parking write, no further write is issued until `pll_locked` is high.
- R6: The new rate is matched exactly against the valid table entries, and the lowest matching index wins. On a miss, `done` and `error` pulse together and no write follows the parking write.
- R7: The return to the main source is one write of 0x1F40_0000 to address 0x50.
- R8: A rising rate writes the matched entry's auxiliary slots in slot order before the return write. A falling rate writes them after it. An unchanged rate writes none.
- R9: An auxiliary slot whose address is 0 issues no write.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R11: `core_sel` and `core_div` follow the masked writes accepted to address 0x50, starting from 0 at reset. `core_rate` = `parent_rate` / (`core_div` + 1).
- R12: `tbl_wr` stores a rate, slot addresses and slot values into entry `tbl_idx`. After reset, every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Rate-change request |
| req_old_rate | input | 32 | Rate before the change |
| req_new_rate | input | 32 | Rate after the change |
| req_alt_rate | input | 32 | Alternate source rate |
| pll_locked | input | 1 | PLL has settled at the new rate |
| tbl_wr | input | 1 | Table entry load strobe |
| tbl_idx | input | 2 | Entry to load |
| tbl_rate | input | 32 | Rate key of the entry |
| tbl_addr | input | 24 | Three slot addresses, slot 0 in the low byte |
| tbl_val | input | 96 | Three masked slot values, slot 0 in the low word |
| parent_rate | input | 32 | Rate of the selected parent, for the report |
| wr_valid | output | 1 | Register write request |
| wr_addr | output | 8 | Register address |
| wr_data | output | 32 | Enable mask [31:16] and data [15:0] |
| wr_ready | input | 1 | Write accepted when high with `wr_valid` |
| core_sel | output | 1 | Shadowed mux select |
| core_div | output | 5 | Shadowed core divider |
| core_rate | output | 32 | Reported core rate |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| error | output | 1 | With `done`: new rate not in table |

## Verification
A write is due only once the parking divider has been computed. That takes one cycle for each step of the count, up to 31. Each later write waits on a random `wr_ready`. For this reason the bench never predicts the cycle a write appears in. It records every accepted handshake and compares the whole ordered sequence against a model once `done` is seen.

The shadowed outputs change at the edge that accepts a core write. The bench therefore checks them at the falling edge after the parking write is logged, while `pll_locked` is held low. It checks them again when `done` is sampled. At that point `done` has risen one edge after the last accepted write, and `busy` is checked low one cycle later.

// File: rtl/cpu_rate_sequencer.sv
module cpu_rate_sequencer #(
  parameter int RATE_W    = 32,
  parameter int DIV_W     = 5,
  parameter int DIV_SHIFT = 8,
  parameter int MUX_BIT   = 6,
  parameter int ADDR_W    = 8,
  parameter int CORE_ADDR = 8'h50,
  parameter int N_ENT     = 4,
  parameter int N_AUX     = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [RATE_W-1:0]       req_old_rate,
  input  logic [RATE_W-1:0]       req_new_rate,
  input  logic [RATE_W-1:0]       req_alt_rate,
  input  logic                    pll_locked,
  input  logic                    tbl_wr,
  input  logic [$clog2(N_ENT)-1:0] tbl_idx,
  input  logic [RATE_W-1:0]       tbl_rate,
  input  logic [N_AUX*ADDR_W-1:0] tbl_addr,
  input  logic [N_AUX*32-1:0]     tbl_val,
  input  logic [RATE_W-1:0]       parent_rate,
  output logic                    wr_valid,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [31:0]             wr_data,
  input  logic                    wr_ready,
  output logic                    core_sel,
  output logic [DIV_W-1:0]        core_div,
  output logic [RATE_W-1:0]       core_rate,
  output logic                    busy,
  output logic                    done,
  output logic                    error
);
  localparam int IDX_W  = $clog2(N_ENT);
  localparam int SLOT_W = (N_AUX > 1) ? $clog2(N_AUX) : 1;
  localparam int ACC_W  = RATE_W + DIV_W + 1;
  localparam logic [DIV_W-1:0]  DMAX   = {DIV_W{1'b1}};
  localparam logic [15:0]       MUX_M  = 16'(1) << MUX_BIT;
  localparam logic [15:0]       DIV_M  = 16'(DMAX) << DIV_SHIFT;
  localparam logic [ADDR_W-1:0] CORE_A = ADDR_W'(CORE_ADDR);
  localparam logic [SLOT_W-1:0] LAST   = SLOT_W'(N_AUX - 1);

  typedef enum logic [3:0] {
    IDLE, PRE_CALC, PRE_WRITE, WAIT_PLL, LOOKUP,
    AUX_EARLY, REMUX, AUX_LATE, FIN
  } st_t;

  st_t st;
  logic [RATE_W-1:0] old_q, new_q, alt_q;
  logic [ACC_W-1:0]  acc;
  logic [DIV_W-1:0]  cnt;
  logic              need, err;
  logic [IDX_W-1:0]  sel;
  logic [SLOT_W-1:0] slot;
  logic [15:0]       core_q;

  logic                  t_vld  [N_ENT];
  logic [RATE_W-1:0]     t_rate [N_ENT];
  logic [ADDR_W-1:0]     t_addr [N_ENT][N_AUX];
  logic [31:0]           t_val  [N_ENT][N_AUX];

  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (t_vld[i] && t_rate[i] == new_q) begin
        hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
  end

  logic [ADDR_W-1:0] s_addr;
  logic [31:0]       s_val;
  assign s_addr = t_addr[sel][slot];
  assign s_val  = t_val[sel][slot];

  logic aux_st, adv;
  assign aux_st = (st == AUX_EARLY) || (st == AUX_LATE);
  assign adv    = (s_addr == '0) || wr_ready;

  always_comb begin
    wr_valid = 1'b0;
    wr_addr  = CORE_A;
    wr_data  = '0;
    case (st)
      PRE_WRITE: begin
        wr_valid = 1'b1;
        wr_data  = need ? {DIV_M | MUX_M, (16'(cnt) << DIV_SHIFT) | MUX_M}
                        : {MUX_M, MUX_M};
      end
      REMUX: begin
        wr_valid = 1'b1;
        wr_data  = {DIV_M | MUX_M, 16'h0000};
      end
      AUX_EARLY, AUX_LATE: begin
        wr_valid = (s_addr != '0);
        wr_addr  = s_addr;
        wr_data  = s_val;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int e = 0; e < N_ENT; e++) begin
        t_vld[e]  <= 1'b0;
        t_rate[e] <= '0;
        for (int s = 0; s < N_AUX; s++) begin
          t_addr[e][s] <= '0;
          t_val[e][s]  <= '0;
        end
      end
    end else if (tbl_wr) begin
      t_vld[tbl_idx]  <= 1'b1;
      t_rate[tbl_idx] <= tbl_rate;
      for (int s = 0; s < N_AUX; s++) begin
        t_addr[tbl_idx][s] <= tbl_addr[s*ADDR_W +: ADDR_W];
        t_val[tbl_idx][s]  <= tbl_val[s*32 +: 32];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) core_q <= '0;
    else if (wr_valid && wr_ready && wr_addr == CORE_A)
      core_q <= (core_q & ~wr_data[31:16]) | (wr_data[15:0] & wr_data[31:16]);

  assign core_sel  = core_q[MUX_BIT];
  assign core_div  = core_q[DIV_SHIFT +: DIV_W];
  assign core_rate = parent_rate / (RATE_W'(core_div) + RATE_W'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE;
      old_q <= '0; new_q <= '0; alt_q <= '0;
      acc <= '0; cnt <= '0; need <= 1'b0; err <= 1'b0;
      sel <= '0; slot <= '0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          old_q <= req_old_rate;
          new_q <= req_new_rate;
          alt_q <= req_alt_rate;
          acc   <= ACC_W'(req_old_rate);
          cnt   <= '0;
          need  <= req_alt_rate > req_old_rate;
          err   <= 1'b0;
          st    <= PRE_CALC;
        end
        PRE_CALC:
          if (!need || acc >= ACC_W'(alt_q) || cnt == DMAX) st <= PRE_WRITE;
          else begin
            acc <= acc + ACC_W'(old_q);
            cnt <= cnt + 1'b1;
          end
        PRE_WRITE: if (wr_ready) st <= WAIT_PLL;
        WAIT_PLL:  if (pll_locked) st <= LOOKUP;
        LOOKUP: begin
          sel  <= hit_idx;
          slot <= '0;
          if (!hit) begin
            err <= 1'b1;
            st  <= FIN;
          end else st <= (new_q > old_q) ? AUX_EARLY : REMUX;
        end
        AUX_EARLY, AUX_LATE: if (adv) begin
          if (slot == LAST) st <= (st == AUX_EARLY) ? REMUX : FIN;
          else slot <= slot + 1'b1;
        end
        REMUX: if (wr_ready) begin
          slot <= '0;
          st   <= (new_q < old_q) ? AUX_LATE : FIN;
        end
        FIN: st <= IDLE;
        default: st <= IDLE;
      endcase
    end

  assign busy  = (st != IDLE);
  assign done  = (st == FIN);
  assign error = done && err;
  logic unused_ok;
  assign unused_ok = aux_st;
endmodule

// File: rtl/rate_seq_checks.sv
module rate_seq_checks #(
  parameter int DIV_W  = 5,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              core_sel,
  input logic [DIV_W-1:0]  core_div
);
  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy);
  assert_done_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_write_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);
  assert_main_undivided_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !core_sel |-> core_div == '0);
  assert_error_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);
  assert_returned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !error |-> !core_sel && core_div == '0);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
endmodule

bind cpu_rate_sequencer rate_seq_checks #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_rate_seq_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .error(error), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .core_sel(core_sel), .core_div(core_div)
);

// File: tb/test_cpu_rate_sequencer.sv
module test_cpu_rate_sequencer;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, pll_locked = 0, tbl_wr = 0, wr_ready = 0;
  logic [31:0] req_old_rate = 0, req_new_rate = 0, req_alt_rate = 0, tbl_rate = 0;
  logic [1:0]  tbl_idx = 0;
  logic [23:0] tbl_addr = 0;
  logic [95:0] tbl_val = 0;
  logic [31:0] parent_rate = 32'd1200;
  logic        wr_valid, core_sel, busy, done, error;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data, core_rate;
  logic [4:0]  core_div;

  cpu_rate_sequencer i_cpu_rate_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_old_rate(req_old_rate),
    .req_new_rate(req_new_rate), .req_alt_rate(req_alt_rate), .pll_locked(pll_locked),
    .tbl_wr(tbl_wr), .tbl_idx(tbl_idx), .tbl_rate(tbl_rate), .tbl_addr(tbl_addr),
    .tbl_val(tbl_val), .parent_rate(parent_rate), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready), .core_sel(core_sel),
    .core_div(core_div), .core_rate(core_rate), .busy(busy), .done(done), .error(error));

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0]  log_a [64];
  logic [31:0] log_d [64];
  int log_n = 0;
  logic [7:0]  exp_a [16];
  logic [31:0] exp_d [16];
  int exp_n;
  logic        b_vld [4];
  logic [31:0] b_rate [4];
  logic [7:0]  b_addr [4][3];
  logic [31:0] b_val [4][3];
  logic [15:0] m_core = 0;
  logic        rnd_ready = 1;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst_n && wr_valid && wr_ready && log_n < 64) begin
      log_a[log_n] = wr_addr;
      log_d[log_n] = wr_data;
      log_n++;
    end
  end

  always @(negedge clk) wr_ready <= rnd_ready ? ($urandom % 3 != 0) : 1'b1;

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [15:0] apply(input logic [15:0] r, input logic [31:0] w);
    return (r & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  task automatic load(input int idx, input logic [31:0] rate,
                      input logic [7:0] a0, a1, a2, input logic [31:0] v0, v1, v2);
    @(negedge clk);
    tbl_wr = 1; tbl_idx = 2'(idx); tbl_rate = rate;
    tbl_addr = {a2, a1, a0}; tbl_val = {v2, v1, v0};
    b_vld[idx] = 1; b_rate[idx] = rate;
    b_addr[idx][0] = a0; b_addr[idx][1] = a1; b_addr[idx][2] = a2;
    b_val[idx][0] = v0; b_val[idx][1] = v1; b_val[idx][2] = v2;
    @(negedge clk);
    tbl_wr = 0;
  endtask

  task automatic run(input logic [31:0] o, input logic [31:0] n, input logic [31:0] a);
    longint q;
    int hit;
    logic [15:0] park_model;
    // expected sequence
    exp_n = 0;
    if (a > o) begin
      q = (longint'(a) + o - 1) / o - 1;
      if (q > 31) q = 31;
      exp_a[0] = 8'h50; exp_d[0] = {16'h1F40, 16'(q << 8) | 16'h0040};
    end else begin
      exp_a[0] = 8'h50; exp_d[0] = 32'h0040_0040;
    end
    exp_n = 1;
    park_model = apply(m_core, exp_d[0]);
    hit = -1;
    for (int i = 3; i >= 0; i--) if (b_vld[i] && b_rate[i] == n) hit = i;
    if (hit >= 0) begin
      if (n > o)
        for (int s = 0; s < 3; s++)
          if (b_addr[hit][s] != 0) begin exp_a[exp_n] = b_addr[hit][s]; exp_d[exp_n] = b_val[hit][s]; exp_n++; end
      exp_a[exp_n] = 8'h50; exp_d[exp_n] = 32'h1F40_0000; exp_n++;
      if (n < o)
        for (int s = 0; s < 3; s++)
          if (b_addr[hit][s] != 0) begin exp_a[exp_n] = b_addr[hit][s]; exp_d[exp_n] = b_val[hit][s]; exp_n++; end
    end
    // drive request
    @(negedge clk);
    log_n = 0;
    chk(!busy, "R1 idle before request", busy, 0);
    req_valid = 1; req_old_rate = o; req_new_rate = n; req_alt_rate = a;
    @(negedge clk);
    req_valid = 0;
    chk(busy, "R1 busy after accept", busy, 1);
    while (log_n < 1) @(negedge clk);
    chk(log_a[0] == exp_a[0] && log_d[0] == exp_d[0], "R2 R3 R4 parking write", log_d[0], exp_d[0]);
    chk(core_sel == park_model[6] && core_div == park_model[12:8], "R11 shadow while parked",
        {core_sel, core_div}, {park_model[6], park_model[12:8]});
    chk(core_rate == parent_rate / (park_model[12:8] + 1), "R11 parked rate",
        core_rate, parent_rate / (park_model[12:8] + 1));
    // request during busy must be ignored
    req_valid = 1; req_new_rate = 32'd7; req_old_rate = 32'd1; req_alt_rate = 32'd9999;
    @(negedge clk);
    req_valid = 0;
    repeat ($urandom % 6 + 2) @(negedge clk);
    chk(log_n == 1, "R5 no write before lock", log_n, 1);
    pll_locked = 1;
    while (!done) @(negedge clk);
    pll_locked = 0;
    chk(error == (hit < 0), "R6 error flag", error, hit < 0);
    chk(log_n == exp_n, "R6 R8 R9 write count", log_n, exp_n);
    for (int k = 0; k < exp_n && k < log_n; k++)
      chk(log_a[k] == exp_a[k] && log_d[k] == exp_d[k], "R7 R8 write order",
          {log_a[k], log_d[k]}, {exp_a[k], exp_d[k]});
    for (int k = 0; k < exp_n; k++) if (exp_a[k] == 8'h50) m_core = apply(m_core, exp_d[k]);
    chk(core_sel == m_core[6] && core_div == m_core[12:8], "R11 shadow at end",
        {core_sel, core_div}, {m_core[6], m_core[12:8]});
    @(negedge clk);
    chk(!busy && !done, "R1 release after done", {busy, done}, 0);
  endtask

  initial begin
    int rates [4] = '{200, 400, 600, 800};
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) b_vld[i] = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !wr_valid && !done && !core_sel && core_div == 0, "R11 reset state",
        {busy, wr_valid, done, core_sel, core_div}, 0);
    chk(core_rate == 1200, "R11 reset rate", core_rate, 1200);
    rst_n = 1;
    // R12: table empty after reset, any new rate misses
    run(400, 200, 300);
    run(400, 0, 300);
    load(0, 200, 8'h10, 8'h00, 8'h12, 32'h00FF_0011, 32'h0, 32'h0F00_0300);
    load(1, 400, 8'h10, 8'h11, 8'h12, 32'h00FF_0022, 32'h00F0_0050, 32'h0F00_0500);
    load(2, 600, 8'h00, 8'h11, 8'h00, 32'h0, 32'h00F0_0060, 32'h0);
    load(3, 800, 8'h10, 8'h11, 8'h12, 32'h00FF_0044, 32'h00F0_0070, 32'h0F00_0700);
    load(1, 800, 8'h13, 8'h00, 8'h00, 32'hFFFF_1234, 32'h0, 32'h0); // R12 lowest index wins for 800? no: entry1 now 800
    run(200, 600, 1000);   // R8 up, R2 d=4
    run(800, 200, 300);    // R8 down, R4 no park
    run(600, 600, 600);    // equal rate, R9 skips
    run(10, 200, 1000);    // R3 clamp to 31
    run(200, 800, 400);    // R6 entry1 wins over entry3, exact ratio d=1
    run(800, 333, 900);    // R6 miss
    run(333, 200, 500);    // recover from parked
    rnd_ready = 1;
    for (int t = 0; t < 40; t++) begin
      logic [31:0] o, n, a;
      o = ($urandom % 2) ? rates[$urandom % 4] : 32'($urandom % 900 + 20);
      n = ($urandom % 6 == 0) ? 32'($urandom % 900 + 1) : rates[$urandom % 4];
      a = 32'($urandom % (o * 40) + 1);
      run(o, n, a);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule